// File: doc/BRIEF.md
# Timer-Based Auxiliary PWM Generator

This block turns a free-running timestamp counter into a single-pin pulse-width modulator. A 32-bit counter starts at zero and counts functional-clock cycles. When it reaches the end of the programmed period it wraps back to zero. The output pin is high from the wrap point until the counter reaches the compare count, and low for the rest of the period. The pin's high time is therefore the compare count and its cycle length is the period count.

Software writes the registers over a plain byte-addressed read/write bus. Each of the two timing registers (period and compare) exists twice: a live copy that the counter uses, and a staged copy. Writing a live copy changes the waveform at once, which suits setting up a stopped output. Writing a staged copy arms a transfer. The transfer happens on the next wrap, so a running waveform always finishes its current period before the new timing applies. A 16-bit control word holds the run bit, the PWM-mode bit and a two-bit sync-select field. The block has no external preset input, so the sync-select field is only stored.

Top module: `aux_pwm_timer`

## Requirements
- R1: After reset, every defined register reads 0 and `pwmOut` is low.
- R2: A read returns the stored value at each defined offset. These are 0x08 (live period), 0x0C (live compare), 0x10 (staged period), 0x14 (staged compare) and 0x2A (control, 16 bits, returned zero-extended, sync-select field at bits 7:6 included). A read at any other offset returns 0.
- R3: The counter advances only while control bit 4 (run) and control bit 9 (PWM mode) are both 1. If either bit is 0, `pwmOut` is low and the counter holds its value, so a resumed output continues from the held phase.
- R4: With live period P (0 is treated as 1) and live compare C, cycle k after starting from count 0 drives `pwmOut` high when (k mod P) < C, else low. This includes C >= P, which gives a constant high.
- R5: P = 1 with C = 1 gives a constant high, and C = 0 gives a constant low.
- R6: A write to the live period or live compare register changes the waveform from the cycle after the write, even while running.
- R7: Writes to the staged registers leave the live registers and the waveform unchanged until the counter wraps. On that wrap both staged values become live.
- R8: A transfer occurs only if a staged register was written since the previous transfer. A live value written after a transfer is not overwritten at later wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock; all counts are in these cycles |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte offset for reads and writes |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data (control uses bits 15:0) |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| pwmOut | output | 1 | PWM output pin |

## Verification
A fault in the counter or wrap logic shows up as a wrong `pwmOut` level in the same cycle it occurs, so the bench compares the pin every cycle against a phase computed from the requirements. A transfer flag that is stuck set or cleared only shows at the next wrap. It appears either as staged timing that never arrives or as a direct live write that gets undone one period later. The bench therefore watches several periods after each such write. A counter that fails to hold while stopped is exposed only after resume, through a shifted phase.

// File: rtl/aux_pwm_pkg.sv
package aux_pwm_pkg;
  localparam int CNT_W  = 32;
  localparam int ADDR_W = 8;
  localparam int CTRL_W = 16;
  localparam int NUM_TIMING = 2;  // index 0: period, index 1: compare

  localparam logic [ADDR_W-1:0] OFS_PER_ACT = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_CMP_ACT = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_PER_SHD = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CMP_SHD = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h2A;

  localparam int RUN_BIT  = 4;
  localparam int MODE_BIT = 9;

  typedef struct packed {
    logic [NUM_TIMING-1:0] wrAct;
    logic [NUM_TIMING-1:0] wrShd;
    logic                  runEn;
    logic [CNT_W-1:0]      wrData;
  } dpStrobe_t;
endpackage

// File: rtl/aux_pwm_ctrl.sv
module aux_pwm_ctrl
  import aux_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [CNT_W-1:0]  busWrData,
  input  logic [CNT_W-1:0]  perAct,
  input  logic [CNT_W-1:0]  cmpAct,
  input  logic [CNT_W-1:0]  perShd,
  input  logic [CNT_W-1:0]  cmpShd,
  output dpStrobe_t         strb,
  output logic [CNT_W-1:0]  busRdData
);
  logic [CTRL_W-1:0] ctrlReg;
  logic              hitCtrl;

  assign hitCtrl = busWrEn && (busAddr == OFS_CTRL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        ctrlReg <= '0;
    else if (hitCtrl) ctrlReg <= busWrData[CTRL_W-1:0];
  end

  always_comb begin
    strb.wrData   = busWrData;
    strb.wrAct[0] = busWrEn && (busAddr == OFS_PER_ACT);
    strb.wrAct[1] = busWrEn && (busAddr == OFS_CMP_ACT);
    strb.wrShd[0] = busWrEn && (busAddr == OFS_PER_SHD);
    strb.wrShd[1] = busWrEn && (busAddr == OFS_CMP_SHD);
    strb.runEn    = ctrlReg[RUN_BIT] & ctrlReg[MODE_BIT];
  end

  always_comb begin
    case (busAddr)
      OFS_PER_ACT: busRdData = perAct;
      OFS_CMP_ACT: busRdData = cmpAct;
      OFS_PER_SHD: busRdData = perShd;
      OFS_CMP_SHD: busRdData = cmpShd;
      OFS_CTRL:    busRdData = {{(CNT_W-CTRL_W){1'b0}}, ctrlReg};
      default:     busRdData = '0;
    endcase
  end
endmodule

// File: rtl/aux_pwm_datapath.sv
module aux_pwm_datapath
  import aux_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  output logic [CNT_W-1:0] perAct,
  output logic [CNT_W-1:0] cmpAct,
  output logic [CNT_W-1:0] perShd,
  output logic [CNT_W-1:0] cmpShd,
  output logic [CNT_W-1:0] cntNow,
  output logic             pendFlag,
  output logic             wrapNow,
  output logic             pwmOut
);
  logic [CNT_W-1:0] actReg [NUM_TIMING];
  logic [CNT_W-1:0] shdReg [NUM_TIMING];
  logic [CNT_W-1:0] perEff;
  logic             loadShd;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_TIMING; gi++) begin : g_timing
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                actReg[gi] <= '0;
        else if (strb.wrAct[gi])  actReg[gi] <= strb.wrData;
        else if (loadShd)         actReg[gi] <= shdReg[gi];
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               shdReg[gi] <= '0;
        else if (strb.wrShd[gi]) shdReg[gi] <= strb.wrData;
      end
    end
  endgenerate

  assign perAct = actReg[0];
  assign cmpAct = actReg[1];
  assign perShd = shdReg[0];
  assign cmpShd = shdReg[1];

  assign perEff  = (perAct == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : perAct;
  assign wrapNow = strb.runEn && (cntNow >= perEff - 1'b1);
  assign loadShd = wrapNow && pendFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cntNow <= '0;
    else if (wrapNow)     cntNow <= '0;
    else if (strb.runEn)  cntNow <= cntNow + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pendFlag <= 1'b0;
    else if (|strb.wrShd)   pendFlag <= 1'b1;
    else if (loadShd)       pendFlag <= 1'b0;
  end

  assign pwmOut = strb.runEn && (cntNow < cmpAct);
endmodule

// File: rtl/aux_pwm_timer.sv
module aux_pwm_timer
  import aux_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [CNT_W-1:0]  busWrData,
  output logic [CNT_W-1:0]  busRdData,
  output logic              pwmOut
);
  dpStrobe_t        strb;
  logic [CNT_W-1:0] perAct, cmpAct, perShd, cmpShd, cntNow;
  logic             pendFlag, wrapNow, runEn;

  assign runEn = strb.runEn;

  aux_pwm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .perAct(perAct), .cmpAct(cmpAct),
    .perShd(perShd), .cmpShd(cmpShd), .strb(strb), .busRdData(busRdData)
  );

  aux_pwm_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .perAct(perAct), .cmpAct(cmpAct),
    .perShd(perShd), .cmpShd(cmpShd), .cntNow(cntNow), .pendFlag(pendFlag),
    .wrapNow(wrapNow), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/aux_pwm_checker.sv
module aux_pwm_checker
  import aux_pwm_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [CNT_W-1:0]  busRdData,
  input logic              runEn,
  input logic [CNT_W-1:0]  cntNow,
  input logic [CNT_W-1:0]  perAct,
  input logic [CNT_W-1:0]  cmpAct,
  input logic              pendFlag,
  input logic              wrapNow,
  input logic              pwmOut
);
  logic addrDefined, wrActAny, wrShdAny;
  assign addrDefined = (busAddr == OFS_PER_ACT) || (busAddr == OFS_CMP_ACT) ||
                       (busAddr == OFS_PER_SHD) || (busAddr == OFS_CMP_SHD) ||
                       (busAddr == OFS_CTRL);
  assign wrActAny = busWrEn && ((busAddr == OFS_PER_ACT) || (busAddr == OFS_CMP_ACT));
  assign wrShdAny = busWrEn && ((busAddr == OFS_PER_SHD) || (busAddr == OFS_CMP_SHD));

  AST_RD_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !addrDefined |-> busRdData == '0); // R2
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> !pwmOut); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> $stable(cntNow)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    runEn && !wrapNow |=> cntNow == $past(cntNow) + 1'b1); // R4
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    wrapNow |=> cntNow == '0); // R4
  AST_SHADOW_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    !wrapNow && !wrActAny |=> $stable(perAct) && $stable(cmpAct)); // R7
  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    wrapNow && pendFlag && !wrShdAny |=> !pendFlag); // R8
  AST_NO_STALE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !pendFlag && !wrActAny |=> $stable(perAct) && $stable(cmpAct)); // R8
endmodule

bind aux_pwm_timer aux_pwm_checker u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busRdData(busRdData), .runEn(runEn), .cntNow(cntNow), .perAct(perAct),
  .cmpAct(cmpAct), .pendFlag(pendFlag), .wrapNow(wrapNow), .pwmOut(pwmOut)
);

// File: tb/test_aux_pwm_timer.sv
module test_aux_pwm_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = 32'h0;
  logic [31:0] busRdData;
  logic        pwmOut;
  int total = 0;
  int bad = 0;
  bit doneFlag = 1'b0;

  always #2.5 clk = ~clk;

  aux_pwm_timer i_aux_pwm_timer (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .pwmOut(pwmOut)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0; busWrEn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // ends at the falling edge just after the write edge
  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic readCheck(input logic [7:0] a, input logic [31:0] exp, input string req);
    busAddr = a; #1;
    check(busRdData == exp, req, busRdData, exp);
  endtask

  // checks n cycles; cycle j has phase (startPh + j) mod per
  task automatic waveCheck(input int n, input int startPh, input int per, input int cmp, input string req);
    for (int j = 0; j < n; j++) begin
      bit expv;
      expv = ((startPh + j) % per) < cmp;
      check(pwmOut == expv, req, pwmOut, expv);
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    check(pwmOut == 1'b0, "R1", pwmOut, 0);
    readCheck(8'h08, 0, "R1"); readCheck(8'h0C, 0, "R1");
    readCheck(8'h10, 0, "R1"); readCheck(8'h14, 0, "R1");
    readCheck(8'h2A, 0, "R1");
  endtask

  task automatic testReadback();
    doReset();
    busWrite(8'h08, 32'hDEAD_0001); busWrite(8'h0C, 32'h1234_5678);
    busWrite(8'h10, 32'h0BAD_F00D); busWrite(8'h14, 32'hFFFF_FFFE);
    busWrite(8'h2A, 32'hABCD_00C0);
    readCheck(8'h08, 32'hDEAD_0001, "R2"); readCheck(8'h0C, 32'h1234_5678, "R2");
    readCheck(8'h10, 32'h0BAD_F00D, "R2"); readCheck(8'h14, 32'hFFFF_FFFE, "R2");
    readCheck(8'h2A, 32'h0000_00C0, "R2");
    readCheck(8'h00, 0, "R2"); readCheck(8'h04, 0, "R2");
    readCheck(8'h18, 0, "R2"); readCheck(8'h28, 0, "R2");
    check(pwmOut == 1'b0, "R3", pwmOut, 0);
  endtask

  task automatic testWave();
    doReset();
    busWrite(8'h08, 5); busWrite(8'h0C, 2); busWrite(8'h2A, 32'h0210);
    waveCheck(15, 0, 5, 2, "R4");
    doReset();
    busWrite(8'h08, 3); busWrite(8'h0C, 7); busWrite(8'h2A, 32'h02D0);
    waveCheck(9, 0, 3, 7, "R4");
  endtask

  task automatic testIdle();
    doReset();
    busWrite(8'h08, 4); busWrite(8'h0C, 2);
    busWrite(8'h2A, 32'h0010);
    waveCheck(6, 0, 4, 0, "R3");
    busWrite(8'h2A, 32'h0200);
    waveCheck(6, 0, 4, 0, "R3");
    busWrite(8'h2A, 32'h0210);
    waveCheck(6, 0, 4, 2, "R3");
    busWrite(8'h2A, 32'h0200);   // stops with count at 3
    waveCheck(5, 0, 4, 0, "R3");
    busWrite(8'h2A, 32'h0210);
    waveCheck(9, 3, 4, 2, "R3");
  endtask

  task automatic testSingle();
    doReset();
    busWrite(8'h08, 1); busWrite(8'h0C, 1); busWrite(8'h2A, 32'h0210);
    waveCheck(8, 0, 1, 1, "R5");
    busWrite(8'h0C, 0);
    waveCheck(5, 0, 1, 0, "R5");
  endtask

  task automatic testLive();
    doReset();
    busWrite(8'h08, 8); busWrite(8'h0C, 2); busWrite(8'h2A, 32'h0210);
    waveCheck(3, 0, 8, 2, "R6");
    busWrite(8'h0C, 6);
    waveCheck(8, 4, 8, 6, "R6");
  endtask

  task automatic testShadow();
    doReset();
    busWrite(8'h08, 6); busWrite(8'h0C, 3); busWrite(8'h2A, 32'h0210);
    waveCheck(2, 0, 6, 3, "R7");
    busWrite(8'h10, 4);
    busWrite(8'h14, 1);
    readCheck(8'h08, 6, "R7"); readCheck(8'h0C, 3, "R7");
    waveCheck(2, 4, 6, 3, "R7");
    waveCheck(12, 0, 4, 1, "R7");
    readCheck(8'h08, 4, "R7"); readCheck(8'h0C, 1, "R7");
    // R8: live compare written after the transfer must survive later wraps
    busWrite(8'h0C, 3);
    waveCheck(12, 1, 4, 3, "R8");
    readCheck(8'h0C, 3, "R8");
  endtask

  initial begin
    doReset();
    testReset();
    testReadback();
    testWave();
    testIdle();
    testSingle();
    testLive();
    testShadow();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!doneFlag) begin
      doneFlag = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule